// File: doc/BRIEF.md
# Double-Buffered ADPCM Sample Stream Prefetcher

This block keeps one fixed-rate 4-bit ADPCM voice supplied with codes while the sample data sits in slow external memory. Sample data is organised in blocks of 16 bytes, each holding 32 four-bit codes. The block owns two block-sized buffers that it uses alternately. It reads whole blocks through a request/acknowledge port, and it hands one code to a downstream decoder on every sample tick.

A key-on pulse latches a first and a last block address and starts the fetch of the first block. The first codes come out only after that fetch has completed, so the start-up delay depends on the memory. From then on the refill point is fixed by playback alone. When the last code of block k has been consumed, the buffer that held it is freed, and block k+2 is requested into it in the next cycle. Playback ends after the last block has been consumed. A key-off pulse, or a new key-on, abandons everything in flight.

Top module: `adpcm_pf_top`

## Requirements
- R1: While reset is applied and after it is released, `mem_req`, `code_valid`, `busy`, `done` and `underrun` are all 0.
- R2: Key-on latches `start_blk` and `end_blk`. The block addresses then requested are start, start+1 and so on up to end, each exactly once, and no address above end is ever requested (the start address must not exceed the end address).
- R3: Once `mem_req` is high, it stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is high, unless a key-on or key-off arrives.
- R4: After key-on, both buffers are filled without waiting for playback. The request for the second block follows the acknowledge of the first, and once both buffers are full no request is made until a block finishes playing.
- R5: A block arriving on `mem_data` holds byte i in bits [8i+7:8i]. Codes are delivered byte 0 first, with the high nibble [7:4] before the low nibble [3:0], giving 32 codes per block. Each code appears on `code` with `code_valid` high in the cycle after the clock edge that samples `tick`.
- R6: Ticks that arrive after key-on but before the first block has been stored produce no code and leave `underrun` at 0.
- R7: When a tick consumes the last code of block k, and block k+2 does not lie beyond the end address, `mem_req` is low in the following cycle, then high one cycle later with `mem_addr` equal to k+2.
- R8: A tick that arrives after playback has started, while the buffer due next is still empty, yields `code_valid` with code 0 and sets `underrun`. The read position does not advance, and `underrun` stays set until the next key-on clears it.
- R9: Once the last code of the end block has been delivered, `done` goes to 1 and `busy` to 0, and later ticks produce no code.
- R10: Key-off drops any request on the following edge, empties both buffers and clears `busy`, and later ticks produce no code. A new key-on restarts cleanly from its own start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_on | input | 1 | One-cycle pulse that starts a voice |
| key_off | input | 1 | One-cycle pulse that stops the voice |
| start_blk | input | ADDR_W | First block address, sampled on key-on |
| end_blk | input | ADDR_W | Last block address, sampled on key-on |
| tick | input | 1 | Sample-rate strobe, one cycle wide |
| mem_req | output | 1 | Block read request |
| mem_addr | output | ADDR_W | Block address of the request |
| mem_ack | input | 1 | Read data valid and request accepted |
| mem_data | input | BLK_BYTES*8 | Whole block, byte i in bits [8i+7:8i] |
| code_valid | output | 1 | A code is presented this cycle |
| code | output | 4 | ADPCM code for the decoder |
| busy | output | 1 | Voice active (waiting for data or playing) |
| done | output | 1 | End block fully played |
| underrun | output | 1 | Sticky flag: a tick found no data ready |

## Verification
The assertions assume a well-behaved environment on the inputs. `mem_ack` is raised only while `mem_req` is high and is dropped once it has been seen, the start address never exceeds the end address, and key-on and key-off are never raised together. The memory model in the bench follows these rules: it counts latency only while a request is pending, and it forgets any request that is withdrawn. The stimulus applies every key pulse for exactly one cycle and always sets up addresses in ascending order.

// File: rtl/adpcm_pf_pkg.sv
package adpcm_pf_pkg;

  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_WAIT = 2'd1,
    PL_RUN  = 2'd2
  } play_st_e;

endpackage

// File: rtl/adpcm_pf_bufs.sv
module adpcm_pf_bufs #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BLK_W-1:0] wr_data,
  input  logic             free_en,
  input  logic             free_sel,
  input  logic             rd_sel,
  output logic [BLK_W-1:0] rd_data,
  output logic [1:0]       full
);

  logic [BLK_W-1:0] data_w [2];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic             we;
    logic             fr;
    logic             full_d;
    logic             full_q;
    logic [BLK_W-1:0] data_q;

    assign we = wr_en && (wr_sel == 1'(b));
    assign fr = free_en && (free_sel == 1'(b));

    always_comb begin
      full_d = full_q;
      if (flush)   full_d = 1'b0;
      else if (we) full_d = 1'b1;
      else if (fr) full_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) full_q <= 1'b0;
      else        full_q <= full_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_q <= '0;
      else if (we) data_q <= wr_data;
    end

    assign data_w[b] = data_q;
    assign full[b]   = full_q;
  end

  assign rd_data = data_w[rd_sel];

  // R4/R7: the fetch side only fills a buffer that playback has released
  p_fill_empty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |-> !full[wr_sel]);

  // R5: playback never releases a buffer that holds no data
  p_free_full_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_en && !flush) |-> full[free_sel]);

endmodule

// File: rtl/adpcm_pf_fetch.sv
module adpcm_pf_fetch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              launch,
  input  logic [ADDR_W-1:0] start_blk,
  input  logic [ADDR_W-1:0] end_blk,
  input  logic              run,
  input  logic [1:0]        buf_full,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_en,
  output logic              wr_sel
);

  logic              req_q,  req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] end_q,  end_d;
  logic              sel_q,  sel_d;
  logic              last_q, last_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    end_d  = end_q;
    sel_d  = sel_q;
    last_d = last_q;
    if (flush) begin
      req_d  = 1'b0;
      sel_d  = 1'b0;
      last_d = 1'b0;
      if (launch) begin
        addr_d = start_blk;
        end_d  = end_blk;
      end
    end else if (req_q) begin
      if (mem_ack) begin
        req_d = 1'b0;
        sel_d = ~sel_q;
        if (addr_q == end_q) last_d = 1'b1;
        else                 addr_d = addr_q + ADDR_W'(1);
      end
    end else if (run && !last_q && !buf_full[sel_q]) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      end_q  <= '0;
      sel_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      end_q  <= end_d;
      sel_q  <= sel_d;
      last_q <= last_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign wr_en    = req_q && mem_ack && !flush;
  assign wr_sel   = sel_q;

  // R3: a pending request is held until it is acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !flush) |=> mem_req);

  // R3: the address of a pending request does not move
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !flush) |=> $stable(mem_addr));

  // R2: nothing beyond the latched end block is requested
  p_no_beyond_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr <= end_q));

endmodule

// File: rtl/adpcm_pf_play.sv
module adpcm_pf_play
  import adpcm_pf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  key_on,
  input  logic                  key_off,
  input  logic [ADDR_W-1:0]     start_blk,
  input  logic [ADDR_W-1:0]     end_blk,
  input  logic                  tick,
  input  logic [1:0]            buf_full,
  input  logic [BLK_BYTES*8-1:0] rd_data,
  output logic                  rd_sel,
  output logic                  free_en,
  output logic                  busy,
  output logic                  done,
  output logic                  underrun,
  output logic                  code_valid,
  output logic [CODE_W-1:0]     code
);

  localparam int NIBS      = BLK_BYTES * 2;
  localparam int NIB_IDX_W = $clog2(NIBS);

  play_st_e              st_q,   st_d;
  logic                  sel_q,  sel_d;
  logic [NIB_IDX_W-1:0]  nib_q,  nib_d;
  logic [ADDR_W-1:0]     blk_q,  blk_d;
  logic [ADDR_W-1:0]     end_q,  end_d;
  logic                  done_q, done_d;
  logic                  und_q,  und_d;
  logic                  cv_q,   cv_d;
  logic [CODE_W-1:0]     code_q, code_d;
  logic [7:0]            cur_byte;
  logic [CODE_W-1:0]     cur_nib;

  always_comb begin
    cur_byte = rd_data[nib_q[NIB_IDX_W-1:1]*8 +: 8];
    cur_nib  = nib_q[0] ? cur_byte[3:0] : cur_byte[7:4];
  end

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    nib_d   = nib_q;
    blk_d   = blk_q;
    end_d   = end_q;
    done_d  = done_q;
    und_d   = und_q;
    cv_d    = 1'b0;
    code_d  = code_q;
    free_en = 1'b0;
    if (key_on) begin
      st_d   = PL_WAIT;
      sel_d  = 1'b0;
      nib_d  = '0;
      blk_d  = start_blk;
      end_d  = end_blk;
      done_d = 1'b0;
      und_d  = 1'b0;
      code_d = '0;
    end else if (key_off) begin
      st_d = PL_IDLE;
    end else if (tick && (st_q != PL_IDLE)) begin
      if (buf_full[sel_q]) begin
        st_d   = PL_RUN;
        cv_d   = 1'b1;
        code_d = cur_nib;
        if (nib_q == NIB_IDX_W'(NIBS - 1)) begin
          nib_d   = '0;
          free_en = 1'b1;
          sel_d   = ~sel_q;
          if (blk_q == end_q) begin
            st_d   = PL_IDLE;
            done_d = 1'b1;
          end else begin
            blk_d = blk_q + ADDR_W'(1);
          end
        end else begin
          nib_d = nib_q + NIB_IDX_W'(1);
        end
      end else if (st_q == PL_RUN) begin
        cv_d   = 1'b1;
        code_d = '0;
        und_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PL_IDLE;
      sel_q  <= 1'b0;
      nib_q  <= '0;
      blk_q  <= '0;
      end_q  <= '0;
      done_q <= 1'b0;
      und_q  <= 1'b0;
      cv_q   <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      nib_q  <= nib_d;
      blk_q  <= blk_d;
      end_q  <= end_d;
      done_q <= done_d;
      und_q  <= und_d;
      cv_q   <= cv_d;
      code_q <= code_d;
    end
  end

  assign rd_sel     = sel_q;
  assign busy       = (st_q != PL_IDLE);
  assign done       = done_q;
  assign underrun   = und_q;
  assign code_valid = cv_q;
  assign code       = code_q;

  // R8: the underrun flag only clears on a key-on
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !key_on) |=> underrun);

  // R8: a starved tick produces a zero code
  p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy && !key_on && !key_off && !buf_full[rd_sel] && st_q == PL_RUN)
      |=> (code_valid && code == '0));

  // R9/R10: an idle voice emits nothing
  p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !key_on) |=> !code_valid);

  // R9: done and busy are never both set
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/adpcm_pf_top.sv
module adpcm_pf_top
  import adpcm_pf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_on,
  input  logic                   key_off,
  input  logic [ADDR_W-1:0]      start_blk,
  input  logic [ADDR_W-1:0]      end_blk,
  input  logic                   tick,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_ack,
  input  logic [BLK_BYTES*8-1:0] mem_data,
  output logic                   code_valid,
  output logic [CODE_W-1:0]      code,
  output logic                   busy,
  output logic                   done,
  output logic                   underrun
);

  localparam int BLK_W = BLK_BYTES * 8;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             flush;
  logic             wr_en;
  logic             wr_sel;
  logic             free_en;
  logic             rd_sel;
  logic [1:0]       buf_full;
  logic [BLK_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign flush = key_on || key_off;

  adpcm_pf_fetch #(.ADDR_W(ADDR_W)) fetch_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .flush     (flush),
    .launch    (key_on),
    .start_blk (start_blk),
    .end_blk   (end_blk),
    .run       (busy),
    .buf_full  (buf_full),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel)
  );

  adpcm_pf_bufs #(.BLK_W(BLK_W)) bufs_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (mem_data),
    .free_en  (free_en),
    .free_sel (rd_sel),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .full     (buf_full)
  );

  adpcm_pf_play #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) play_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .key_on     (key_on),
    .key_off    (key_off),
    .start_blk  (start_blk),
    .end_blk    (end_blk),
    .tick       (tick),
    .buf_full   (buf_full),
    .rd_data    (rd_data),
    .rd_sel     (rd_sel),
    .free_en    (free_en),
    .busy       (busy),
    .done       (done),
    .underrun   (underrun),
    .code_valid (code_valid),
    .code       (code)
  );

  // R10: key-on or key-off withdraws any request on the next edge
  p_flush_drops_req_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (key_on || key_off) |=> !mem_req);

  // R10: after key-off the voice is no longer busy
  p_keyoff_idle_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (key_off && !key_on) |=> !busy);

endmodule

// File: tb/adpcm_pf_top_tb_top.sv
`timescale 1ns/1ps
module adpcm_pf_top_tb_top;

  localparam int AW   = 16;
  localparam int BB   = 16;
  localparam int NIBS = BB * 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          key_on, key_off, tick, mem_ack;
  logic [AW-1:0] start_blk, end_blk;
  logic [BB*8-1:0] mem_data;
  logic          mem_req, code_valid, busy, done, underrun;
  logic [AW-1:0] mem_addr;
  logic [3:0]    code;

  int checks = 0;
  int errors = 0;
  int lat = 6;
  int cnt = 0;
  logic [3:0]    exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] req_log[$];

  always #2 clk = ~clk;

  adpcm_pf_top #(.ADDR_W(AW), .BLK_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
    .start_blk(start_blk), .end_blk(end_blk), .tick(tick),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .code_valid(code_valid), .code(code), .busy(busy), .done(done), .underrun(underrun)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a, input int i);
    return 8'(int'(a) * 37 + i * 11 + 5);
  endfunction

  function automatic logic [3:0] exp_code(input logic [AW-1:0] a, input int j);
    logic [7:0] b;
    b = mem_byte(a, j / 2);
    return (j % 2 == 0) ? b[7:4] : b[3:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model: latency counted while a request is pending
  always @(negedge clk) begin
    if (!rst_n || !mem_req) begin
      cnt = 0;
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else begin
      cnt++;
      if (cnt >= lat) begin
        for (int i = 0; i < BB; i++) mem_data[i*8 +: 8] = mem_byte(mem_addr, i);
        mem_ack = 1'b1;
        req_log.push_back(mem_addr);
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && code_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R9/R10", "unexpected code", int'(code), -1);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(code == e, t, "code", int'(code), int'(e));
      end
    end
  end

  task automatic push_blk(input logic [AW-1:0] a, input int from, input int to);
    for (int j = from; j <= to; j++) begin
      exp_q.push_back(exp_code(a, j));
      tag_q.push_back("R5");
    end
  endtask

  task automatic do_tick(input int gap);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) do_tick(gap);
  endtask

  task automatic pulse_on(input logic [AW-1:0] s, input logic [AW-1:0] e);
    req_log.delete();
    start_blk = s;
    end_blk   = e;
    key_on    = 1'b1;
    @(negedge clk);
    key_on    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; key_on = 1'b0; key_off = 1'b0; tick = 1'b0;
    start_blk = '0; end_blk = '0; mem_ack = 1'b0; mem_data = '0;
    repeat (4) @(negedge clk);
    // R1 during reset
    check(!mem_req && !code_valid && !busy && !done && !underrun, "R1",
          "outputs in reset", int'({mem_req, code_valid, busy, done, underrun}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!mem_req && !code_valid && !busy && !done && !underrun, "R1",
          "outputs after reset", int'({mem_req, code_valid, busy, done, underrun}), 0);

    // Test A: slow first fetch, early ticks ignored, full playback
    lat = 25;
    pulse_on(16'd5, 16'd8);
    ticks(3, 2);                               // R6: before first block
    repeat (80) @(negedge clk);
    check(underrun == 1'b0, "R6", "underrun after early ticks", int'(underrun), 0);
    check(exp_q.size() == 0, "R6", "pending codes", exp_q.size(), 0);
    check(req_log.size() == 2, "R4", "blocks prefetched", req_log.size(), 2);
    check(mem_req == 1'b0, "R4", "idle with both buffers full", int'(mem_req), 0);
    lat = 4;
    for (int b = 5; b <= 8; b++) push_blk(AW'(b), 0, NIBS - 1);
    ticks(4 * NIBS, 6);
    repeat (4) @(negedge clk);
    check(req_log.size() == 4, "R2", "request count", req_log.size(), 4);
    for (int i = 0; i < req_log.size() && i < 4; i++)
      check(req_log[i] == AW'(5 + i), "R2", "request order", int'(req_log[i]), 5 + i);
    check(done == 1'b1 && busy == 1'b0, "R9", "done/busy at end",
          int'({done, busy}), 2);
    ticks(2, 3);                               // R9: no more codes
    check(exp_q.size() == 0, "R9", "codes left", exp_q.size(), 0);

    // Test B: refill timing and underrun
    lat = 6;
    pulse_on(16'd0, 16'd2);
    check(done == 1'b0, "R9", "done cleared by key-on", int'(done), 0);
    repeat (40) @(negedge clk);
    lat = 300;
    push_blk(AW'(0), 0, NIBS - 1);
    ticks(NIBS - 1, 3);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(mem_req == 1'b0, "R7", "req one cycle after last code", int'(mem_req), 0);
    @(negedge clk);
    check(mem_req == 1'b1, "R7", "req two cycles after last code", int'(mem_req), 1);
    check(mem_addr == AW'(2), "R7", "refill address", int'(mem_addr), 2);
    @(negedge clk);
    push_blk(AW'(1), 0, NIBS - 1);
    ticks(NIBS, 3);
    exp_q.push_back(4'h0);
    tag_q.push_back("R8");
    ticks(1, 3);
    check(underrun == 1'b1, "R8", "underrun set", int'(underrun), 1);
    repeat (300) @(negedge clk);
    push_blk(AW'(2), 0, NIBS - 1);             // R8: position not advanced
    ticks(NIBS, 3);
    repeat (3) @(negedge clk);
    check(underrun == 1'b1, "R8", "underrun sticky", int'(underrun), 1);
    check(done == 1'b1, "R9", "done after end block", int'(done), 1);
    check(exp_q.size() == 0, "R8", "codes left", exp_q.size(), 0);

    // Test C: key-off mid block, then restart
    lat = 4;
    pulse_on(16'd3, 16'd9);
    check(underrun == 1'b0, "R8", "underrun cleared by key-on", int'(underrun), 0);
    repeat (30) @(negedge clk);
    push_blk(AW'(3), 0, 9);
    ticks(10, 3);
    key_off = 1'b1;
    @(negedge clk);
    key_off = 1'b0;
    check(mem_req == 1'b0 && busy == 1'b0, "R10", "after key-off",
          int'({mem_req, busy}), 0);
    ticks(3, 3);
    repeat (10) @(negedge clk);
    check(mem_req == 1'b0, "R10", "no request after key-off", int'(mem_req), 0);
    check(exp_q.size() == 0, "R10", "codes left", exp_q.size(), 0);
    pulse_on(16'd20, 16'd20);
    repeat (30) @(negedge clk);
    check(req_log.size() == 1, "R10", "restart request count", req_log.size(), 1);
    if (req_log.size() > 0)
      check(req_log[0] == AW'(20), "R10", "restart address", int'(req_log[0]), 20);
    push_blk(AW'(20), 0, NIBS - 1);
    ticks(NIBS, 3);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R9", "single-block done", int'({done, busy}), 2);
    check(exp_q.size() == 0, "R5", "codes left at end", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule